// File: doc/BRIEF.md
# PSRAM Power-Up and Access Mode Sequencer

This block sits between a host's memory requester and a pseudo-static RAM. After reset it keeps the memory deselected and silent for a fixed settling interval, counted in system clock cycles. When that interval ends it raises `ready` and begins to serve accesses. Before the interval ends it forwards nothing to the memory pins.

Each access arrives on a request/acknowledge port and is played out on the memory's active-low control strobes and on its clock pin. The block supports three access modes:

- **Asynchronous:** every access runs with the clock held low.
- **Synchronous:** reads and writes are framed by rising edges of the memory clock.
- **Mixed:** reads run clocked and writes run asynchronously, with the clock held low.

The host selects a mode with a load strobe. A load is taken only while the block is idle, and the new mode governs the accesses that follow it.

Top module: `psram_mode_seq`

## Requirements
- R1: While `ready` is low, every strobe output (`memCeN`, `memAdvN`, `memOeN`, `memWeN`, `memUbN`, `memLbN`) is high, `memClk` is low and `reqAck` is low.
- R2: `ready` stays low for the first WAIT_CYCLES rising clock edges after reset is released and is high from then on. WAIT_CYCLES = CLK_FREQ_KHZ*WAIT_US/1000, which is 15000 by default.
- R3: A request raised before `ready` is held without an acknowledge and is served once `ready` is high. A mode load issued before `ready` is discarded.
- R4: After the wait the active mode is asynchronous. The `modeSel` codes are 0 for asynchronous, 1 for synchronous and 2 for mixed. A load carrying code 3 is ignored.
- R5: An asynchronous access keeps `memClk` low throughout. `memAdvN` is low for 1 cycle and `memCeN` is low for 1+ASYNC_CYCLES cycles. During those cycles `memOeN` (on a read) or `memWeN` (on a write) is low for ASYNC_CYCLES cycles.
- R6: A synchronous access produces 1+SYNC_BEATS rising edges of `memClk`. `memAdvN` is low for 2 cycles and `memCeN` is low for 2+2*SYNC_BEATS cycles. A write holds `memWeN` low for the 2 address cycles. A read holds `memOeN` low for 2*SYNC_BEATS cycles.
- R7: In mixed mode a read behaves as in R6 and a write behaves as in R5, with `memClk` held low.
- R8: `memUbN` follows `reqByteEn[1]` and `memLbN` follows `reqByteEn[0]`. A selected byte lane is low exactly while `memCeN` is low, and an unselected lane stays high.
- R9: Each access ends with exactly one `reqAck` pulse, one cycle long. All strobes are high in that cycle.
- R10: A mode load arriving during an access is ignored. A load accepted while idle applies from the next access.
- R11: `memOeN` and `memWeN` are never low together, and `memAdvN` is low only while `memCeN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| modeSel | input | 2 | Requested access mode code |
| modeLoad | input | 1 | Strobe to load `modeSel` |
| reqValid | input | 1 | Access request, held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqByteEn | input | 2 | Byte lanes: bit 1 upper, bit 0 lower |
| reqAck | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Settling interval has elapsed |
| memClk | output | 1 | Memory clock pin |
| memCeN | output | 1 | Chip enable, active low |
| memAdvN | output | 1 | Address valid, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memUbN | output | 1 | Upper byte enable, active low |
| memLbN | output | 1 | Lower byte enable, active low |

## Verification
The assertions check on every cycle the properties that hold at all times:

- the silent pins before `ready`;
- the exact cycle on which `ready` rises;
- a single-cycle acknowledge with released strobes;
- the exclusion between output enable and write enable, and between address valid and a deselected chip;
- byte lanes confined to chip-enable windows;
- `memClk` toggling only during a clocked access.

Only the bench scenarios can show the remaining behaviour. This covers the strobe widths and clock edge counts for each mode and direction, a mode load being discarded during the wait, during an access or with code 3, and a pending early request being served after the wait.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_SYNC  = 2'd1,
    MODE_MIXED = 2'd2,
    MODE_RSVD  = 2'd3
  } memMode_t;

  // Strobe bundle from control to pin stage; every field is active high here.
  typedef struct packed {
    logic clkHigh;
    logic ceLow;
    logic advLow;
    logic oeLow;
    logic weLow;
    logic ubLow;
    logic lbLow;
    logic ackPulse;
  } pinCmd_t;

  localparam pinCmd_t PIN_IDLE = '0;

endpackage

// File: rtl/psram_seq_wait.sv
module psram_seq_wait #(
  parameter int unsigned WAIT_CYCLES = 15000
) (
  input  logic clk,
  input  logic rstN,
  output logic ready
);
  localparam int unsigned CW = $clog2(WAIT_CYCLES + 1);

  logic [CW-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      ready   <= 1'b0;
    end else if (!ready) begin
      if (waitCnt == CW'(WAIT_CYCLES - 1)) begin
        ready <= 1'b1;
      end else begin
        waitCnt <= waitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
  import psram_seq_pkg::*;
#(
  parameter int unsigned ASYNC_CYCLES = 3,
  parameter int unsigned SYNC_BEATS   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ready,
  input  logic [1:0] modeSel,
  input  logic       modeLoad,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqByteEn,
  output pinCmd_t    cmd,
  output logic       accSync
);
  localparam int unsigned MAXLEN = (ASYNC_CYCLES > SYNC_BEATS) ? ASYNC_CYCLES : SYNC_BEATS;
  localparam int unsigned BW     = $clog2(MAXLEN + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_A_ADDR, ST_A_DATA, ST_S_ADDR_LO,
    ST_S_ADDR_HI, ST_S_DATA_LO, ST_S_DATA_HI, ST_DONE
  } seqState_t;

  seqState_t      state;
  memMode_t       modeReg;
  logic           accWrite;
  logic [1:0]     accBe;
  logic [BW-1:0]  beatCnt;
  logic           startSync;
  logic           canStart;
  logic           canLoad;

  assign canStart  = ready && reqValid && (state == ST_IDLE);
  assign canLoad   = ready && modeLoad && (state == ST_IDLE) && (modeSel != MODE_RSVD);
  assign startSync = (modeReg == MODE_SYNC) || ((modeReg == MODE_MIXED) && !reqWrite);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modeReg  <= MODE_ASYNC;
      accWrite <= 1'b0;
      accBe    <= 2'b00;
      accSync  <= 1'b0;
      beatCnt  <= '0;
    end else begin
      if (canLoad) modeReg <= memMode_t'(modeSel);
      case (state)
        ST_IDLE: begin
          if (canStart) begin
            accWrite <= reqWrite;
            accBe    <= reqByteEn;
            accSync  <= startSync;
            beatCnt  <= '0;
            state    <= startSync ? ST_S_ADDR_LO : ST_A_ADDR;
          end
        end
        ST_A_ADDR: begin
          beatCnt <= '0;
          state   <= ST_A_DATA;
        end
        ST_A_DATA: begin
          if (beatCnt == BW'(ASYNC_CYCLES - 1)) state <= ST_DONE;
          else beatCnt <= beatCnt + 1'b1;
        end
        ST_S_ADDR_LO: state <= ST_S_ADDR_HI;
        ST_S_ADDR_HI: begin
          beatCnt <= '0;
          state   <= ST_S_DATA_LO;
        end
        ST_S_DATA_LO: state <= ST_S_DATA_HI;
        ST_S_DATA_HI: begin
          if (beatCnt == BW'(SYNC_BEATS - 1)) begin
            state <= ST_DONE;
          end else begin
            beatCnt <= beatCnt + 1'b1;
            state   <= ST_S_DATA_LO;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd = PIN_IDLE;
    case (state)
      ST_A_ADDR, ST_S_ADDR_LO, ST_S_ADDR_HI: begin
        cmd.ceLow   = 1'b1;
        cmd.advLow  = 1'b1;
        cmd.weLow   = accWrite && (state != ST_A_ADDR);
        cmd.ubLow   = accBe[1];
        cmd.lbLow   = accBe[0];
        cmd.clkHigh = (state == ST_S_ADDR_HI);
      end
      ST_A_DATA, ST_S_DATA_LO, ST_S_DATA_HI: begin
        cmd.ceLow   = 1'b1;
        cmd.oeLow   = !accWrite;
        cmd.weLow   = accWrite && (state == ST_A_DATA);
        cmd.ubLow   = accBe[1];
        cmd.lbLow   = accBe[0];
        cmd.clkHigh = (state == ST_S_DATA_HI);
      end
      ST_DONE: cmd.ackPulse = 1'b1;
      default: cmd = PIN_IDLE;
    endcase
  end
endmodule

// File: rtl/psram_seq_pins.sv
module psram_seq_pins
  import psram_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  pinCmd_t cmd,
  output logic    memClk,
  output logic    memCeN,
  output logic    memAdvN,
  output logic    memOeN,
  output logic    memWeN,
  output logic    memUbN,
  output logic    memLbN,
  output logic    reqAck
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memClk  <= 1'b0;
      memCeN  <= 1'b1;
      memAdvN <= 1'b1;
      memOeN  <= 1'b1;
      memWeN  <= 1'b1;
      memUbN  <= 1'b1;
      memLbN  <= 1'b1;
      reqAck  <= 1'b0;
    end else begin
      memClk  <= cmd.clkHigh;
      memCeN  <= !cmd.ceLow;
      memAdvN <= !cmd.advLow;
      memOeN  <= !cmd.oeLow;
      memWeN  <= !cmd.weLow;
      memUbN  <= !cmd.ubLow;
      memLbN  <= !cmd.lbLow;
      reqAck  <= cmd.ackPulse;
    end
  end
endmodule

// File: rtl/psram_mode_seq.sv
module psram_mode_seq
  import psram_seq_pkg::*;
#(
  parameter int unsigned CLK_FREQ_KHZ = 100000,
  parameter int unsigned WAIT_US      = 150,
  parameter int unsigned ASYNC_CYCLES = 3,
  parameter int unsigned SYNC_BEATS   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       modeLoad,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic [1:0] reqByteEn,
  output logic       reqAck,
  output logic       ready,
  output logic       memClk,
  output logic       memCeN,
  output logic       memAdvN,
  output logic       memOeN,
  output logic       memWeN,
  output logic       memUbN,
  output logic       memLbN
);
  localparam int unsigned WAIT_CYCLES = CLK_FREQ_KHZ * WAIT_US / 1000;

  pinCmd_t cmdBus;
  logic    accSync;

  psram_seq_wait #(.WAIT_CYCLES(WAIT_CYCLES)) waitTimer (
    .clk(clk), .rstN(rstN), .ready(ready)
  );

  psram_seq_ctrl #(.ASYNC_CYCLES(ASYNC_CYCLES), .SYNC_BEATS(SYNC_BEATS)) ctrl (
    .clk(clk), .rstN(rstN), .ready(ready), .modeSel(modeSel), .modeLoad(modeLoad),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqByteEn(reqByteEn),
    .cmd(cmdBus), .accSync(accSync)
  );

  psram_seq_pins pins (
    .clk(clk), .rstN(rstN), .cmd(cmdBus),
    .memClk(memClk), .memCeN(memCeN), .memAdvN(memAdvN), .memOeN(memOeN),
    .memWeN(memWeN), .memUbN(memUbN), .memLbN(memLbN), .reqAck(reqAck)
  );
endmodule

// File: rtl/psram_seq_checker.sv
module psram_seq_checker #(
  parameter int unsigned WAIT_CYCLES = 15000
) (
  input logic clk,
  input logic rstN,
  input logic ready,
  input logic reqAck,
  input logic memClk,
  input logic memCeN,
  input logic memAdvN,
  input logic memOeN,
  input logic memWeN,
  input logic memUbN,
  input logic memLbN,
  input logic accSync
);
  localparam int unsigned CW = $clog2(WAIT_CYCLES + 2);

  logic [CW-1:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (edgeCnt != CW'(WAIT_CYCLES + 1)) edgeCnt <= edgeCnt + 1'b1;
  end

  assert_quiet_before_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (memCeN && memAdvN && memOeN && memWeN && memUbN && memLbN && !memClk && !reqAck));

  assert_ready_on_time_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (edgeCnt == CW'(WAIT_CYCLES)));

  assert_ready_sticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  assert_clock_only_clocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    memClk |-> accSync);

  assert_lanes_inside_ce_R8: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> (memUbN && memLbN));

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  assert_ack_released_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (memCeN && memOeN && memWeN && !memClk));

  assert_oe_we_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_adv_needs_ce_R11: assert property (@(posedge clk) disable iff (!rstN)
    !memAdvN |-> !memCeN);
endmodule

bind psram_mode_seq psram_seq_checker #(.WAIT_CYCLES(WAIT_CYCLES)) chk (
  .clk(clk), .rstN(rstN), .ready(ready), .reqAck(reqAck), .memClk(memClk),
  .memCeN(memCeN), .memAdvN(memAdvN), .memOeN(memOeN), .memWeN(memWeN),
  .memUbN(memUbN), .memLbN(memLbN), .accSync(accSync)
);

// File: tb/psram_mode_seq_test.sv
`timescale 1ns/1ps
module psram_mode_seq_test;
  localparam int WAITC = 15000;
  localparam int ACYC  = 3;
  localparam int BEATS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic modeLoad = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqByteEn = 2'b00;
  logic reqAck, ready, memClk, memCeN, memAdvN, memOeN, memWeN, memUbN, memLbN;

  int checks = 0, errors = 0;
  bit monOn = 0, waitMon = 0;
  int ceLow, advLow, oeLow, weLow, ubLow, lbLow, clkRise, clkHigh, waitViol;
  logic prevClk;

  always #5 clk = ~clk;

  psram_mode_seq uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .modeLoad(modeLoad),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqByteEn(reqByteEn),
    .reqAck(reqAck), .ready(ready), .memClk(memClk), .memCeN(memCeN),
    .memAdvN(memAdvN), .memOeN(memOeN), .memWeN(memWeN), .memUbN(memUbN),
    .memLbN(memLbN)
  );

  always @(posedge clk) begin
    #3;
    if (monOn) begin
      if (!memCeN) ceLow++;
      if (!memAdvN) advLow++;
      if (!memOeN) oeLow++;
      if (!memWeN) weLow++;
      if (!memUbN) ubLow++;
      if (!memLbN) lbLow++;
      if (memClk) clkHigh++;
      if (memClk && !prevClk) clkRise++;
      prevClk = memClk;
    end
    if (waitMon && !ready)
      if (!memCeN || !memAdvN || !memOeN || !memWeN || !memUbN || !memLbN || memClk || reqAck)
        waitViol++;
  end

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    ceLow = 0; advLow = 0; oeLow = 0; weLow = 0; ubLow = 0; lbLow = 0;
    clkRise = 0; clkHigh = 0; prevClk = 1'b0;
  endtask

  // Waits for the acknowledge of an already driven request, then checks pin activity.
  task automatic finishAccess(string tag, bit wr, bit [1:0] be, bit expSync,
                              bit loadMid, logic [1:0] midMode);
    bit got = 0;
    int expCe;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      modeLoad = (loadMid && i == 2);
      if (loadMid && i == 2) modeSel = midMode;
      if (reqAck) begin
        got = 1;
        break;
      end
    end
    modeLoad = 1'b0;
    reqValid = 1'b0;
    monOn = 0;
    checkEq({tag, " R9 ack seen"}, int'(got), 1);
    if (expSync) begin
      expCe = 2 + 2 * BEATS;
      checkEq({tag, " R6 clock rises"}, clkRise, 1 + BEATS);
      checkEq({tag, " R6 adv low"}, advLow, 2);
      checkEq({tag, " R6 ce low"}, ceLow, expCe);
      checkEq({tag, " R6 oe low"}, oeLow, wr ? 0 : 2 * BEATS);
      checkEq({tag, " R6 we low"}, weLow, wr ? 2 : 0);
    end else begin
      expCe = 1 + ACYC;
      checkEq({tag, " R5 clock high"}, clkHigh, 0);
      checkEq({tag, " R5 adv low"}, advLow, 1);
      checkEq({tag, " R5 ce low"}, ceLow, expCe);
      checkEq({tag, " R5 oe low"}, oeLow, wr ? 0 : ACYC);
      checkEq({tag, " R5 we low"}, weLow, wr ? ACYC : 0);
    end
    checkEq({tag, " R8 ub low"}, ubLow, be[1] ? expCe : 0);
    checkEq({tag, " R8 lb low"}, lbLow, be[0] ? expCe : 0);
    @(negedge clk);
    checkEq({tag, " R9 ack one cycle"}, int'(reqAck), 0);
  endtask

  task automatic runAccess(string tag, bit wr, bit [1:0] be, bit expSync,
                           bit loadMid = 0, logic [1:0] midMode = 2'd0);
    @(negedge clk);
    clearMon();
    monOn = 1;
    reqValid = 1'b1;
    reqWrite = wr;
    reqByteEn = be;
    finishAccess(tag, wr, be, expSync, loadMid, midMode);
  endtask

  task automatic setMode(logic [1:0] m);
    @(negedge clk);
    modeSel = m;
    modeLoad = 1'b1;
    @(negedge clk);
    modeLoad = 1'b0;
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #2;
    checkEq("R1 reset ce", int'(memCeN), 1);
    checkEq("R1 reset clk", int'(memClk), 0);
    checkEq("R1 reset ready", int'(ready), 0);
    checkEq("R1 reset ack", int'(reqAck), 0);
  endtask

  task automatic testPowerUp();
    // Early request and early mode load to synchronous; the load must be dropped (R3).
    reqValid = 1'b1;
    reqWrite = 1'b0;
    reqByteEn = 2'b11;
    modeSel = 2'd1;
    modeLoad = 1'b1;
    waitViol = 0;
    waitMon = 1;
    @(negedge clk);
    rstN = 1'b1;
    repeat (WAITC - 1) @(posedge clk);
    #2;
    checkEq("R2 ready still low", int'(ready), 0);
    modeLoad = 1'b0;
    @(posedge clk);
    #2;
    checkEq("R2 ready high", int'(ready), 1);
    waitMon = 0;
    checkEq("R1 quiet pins during wait", waitViol, 0);
    clearMon();
    monOn = 1;
    finishAccess("R3 held read served async R4", 1'b0, 2'b11, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic testAsync();
    runAccess("async write lower R5", 1'b1, 2'b01, 1'b0);
    runAccess("async read upper R5", 1'b0, 2'b10, 1'b0);
  endtask

  task automatic testSync();
    setMode(2'd1);
    runAccess("sync read R6", 1'b0, 2'b11, 1'b1);
    runAccess("sync write R6", 1'b1, 2'b10, 1'b1);
  endtask

  task automatic testMixed();
    setMode(2'd2);
    runAccess("mixed read R7", 1'b0, 2'b01, 1'b1);
    runAccess("mixed write R7", 1'b1, 2'b11, 1'b0);
  endtask

  task automatic testReservedCode();
    setMode(2'd3);
    runAccess("code3 ignored write R4", 1'b1, 2'b11, 1'b0);
    runAccess("code3 ignored read R4", 1'b0, 2'b11, 1'b1);
  endtask

  task automatic testMidAccessLoad();
    setMode(2'd0);
    runAccess("load during access R10", 1'b0, 2'b11, 1'b0, 1'b1, 2'd1);
    runAccess("after dropped load R10", 1'b0, 2'b11, 1'b0);
    setMode(2'd1);
    runAccess("idle load applies R10", 1'b1, 2'b01, 1'b1);
  endtask

  initial begin
    #3_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testPowerUp();
    testAsync();
    testSync();
    testMixed();
    testReservedCode();
    testMidAccessLoad();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule